// File: doc/BRIEF.md
# Multisample Subsample Write Sequencer

This block accepts pixel fragments one at a time and turns each one into a short burst of subsample writes for a framebuffer port. A fragment carries a colour, a depth value, a six-bit coverage mask and the integer pixel coordinates. Every write beat carries two subsample lanes. To reach higher anti-aliasing levels, the same fragment is looped back through the write stage: two samples need one beat, four need two beats, and six need three.

For each subsample the block looks up a sub-pixel position in a programmable table. The positions lie on a 12x12 grid, so each coordinate is 4 bits wide and ranges from 0 to 11. Two tables are kept. A frame-parity input picks one of them, so software can alternate sample patterns from frame to frame for temporal anti-aliasing.

All the settings that describe a fragment are captured when the fragment is accepted. These are the sample-count mode, the parity and a copy of the chosen table. Because of this, every pass of one pixel sees the same configuration. Back-pressure on the write port stalls the burst. The input side stays closed until the last beat has been taken downstream.

Top module: `msaa_write_seq`

## Requirements
- R1: After reset, fragReady is 1 and wrValid is 0.
- R2: A fragment is taken on a cycle where fragValid and fragReady are both 1. From the next cycle, wrValid is 1 and fragReady is 0. fragReady returns to 1, and wrValid to 0, in the cycle after the beat with wrLast is accepted (wrValid and wrReady both 1).
- R3: modeSel, sampled at acceptance, sets the sample count and the number of beats: 0 gives 1 sample in 1 beat, 1 gives 2 samples in 1 beat, 2 gives 4 samples in 2 beats, and 3 gives 6 samples in 3 beats. wrLast is 1 only on the final beat.
- R4: On beat p (counting from 0), lane 0 (wrIdx[2:0], wrPosX[3:0], wrPosY[3:0], wrEn[0]) carries sample 2p. Lane 1 (wrIdx[5:3], wrPosX[7:4], wrPosY[7:4], wrEn[1]) carries sample 2p+1.
- R5: A lane's enable is 1 only when fragCover bit s is 1 for its sample s and s is below the sample count. An uncovered sample still takes its lane slot. In mode 0, lane 1 is never enabled.
- R6: wrColor, wrDepth, wrX and wrY equal the accepted fragment's values on every beat.
- R7: The positions for sample s come from entry s of table frameOdd, where frameOdd is sampled at acceptance (0 selects table 0, 1 selects table 1).
- R8: When tblWe is 1, entry tblIdx of table tblSel is written with tblX and tblY at the clock edge. A coordinate above 11 is stored as 11.
- R9: Table writes (including one in the acceptance cycle) and changes to modeSel or frameOdd after acceptance do not alter a fragment already taken. They apply from the next fragment.
- R10: While wrValid is 1 and wrReady is 0, every write output holds its value.
- R11: After reset, entry s of both tables holds x = 2s+1 and y = 10-2s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Sample-count mode (0:1, 1:2, 2:4, 3:6) |
| frameOdd | input | 1 | Frame parity, selects position table |
| tblWe | input | 1 | Position table write strobe |
| tblSel | input | 1 | Table written |
| tblIdx | input | 3 | Sample entry written |
| tblX | input | 4 | Sub-pixel x to store |
| tblY | input | 4 | Sub-pixel y to store |
| fragValid | input | 1 | Fragment offered |
| fragReady | output | 1 | Fragment can be taken |
| fragColor | input | COLOR_W | Fragment colour |
| fragDepth | input | DEPTH_W | Fragment depth/stencil |
| fragCover | input | 6 | Per-sample coverage |
| fragX | input | COORD_W | Pixel x |
| fragY | input | COORD_W | Pixel y |
| wrValid | output | 1 | Write beat valid |
| wrReady | input | 1 | Downstream takes beat |
| wrLast | output | 1 | Final beat of fragment |
| wrX | output | COORD_W | Pixel x of beat |
| wrY | output | COORD_W | Pixel y of beat |
| wrColor | output | COLOR_W | Colour for both lanes |
| wrDepth | output | DEPTH_W | Depth for both lanes |
| wrIdx | output | 6 | Sample index per lane |
| wrPosX | output | 8 | Sub-pixel x per lane |
| wrPosY | output | 8 | Sub-pixel y per lane |
| wrEn | output | 2 | Write enable per lane |

## Verification
The bench drives fragments with random modes, parities and coverage masks. This separates errors in beat count, in lane-to-sample mapping, and in masking by coverage or by sample count. Directed fragments with full coverage and no table writes confirm the reset patterns of both tables. A write of out-of-grid values shows whether clamping happens. Random stalls, with table writes and input changes during a stall or in the acceptance cycle itself, show whether the captured snapshot and the held outputs stay intact. Only a wrong snapshot or a wrong hold would change the outputs in that window.

// File: rtl/msaa_pkg.sv
package msaa_pkg;
  // Fixed sample architecture: up to six samples, two lanes per beat.
  localparam int MAX_SAMP = 6;
  localparam int LANES    = 2;
  localparam int IDX_W    = $clog2(MAX_SAMP);
  localparam int PASS_W   = $clog2((MAX_SAMP + LANES - 1) / LANES);
  localparam int MODE_W   = 2;

  // Strobes from the sequencer control to the datapath.
  typedef struct packed {
    logic              load;
    logic [PASS_W-1:0] pass;
  } seq_ctrl_t;

  function automatic logic [IDX_W-1:0] sampleCount(input logic [MODE_W-1:0] mode);
    case (mode)
      2'd0:    sampleCount = IDX_W'(1);
      2'd1:    sampleCount = IDX_W'(2);
      2'd2:    sampleCount = IDX_W'(4);
      default: sampleCount = IDX_W'(6);
    endcase
  endfunction

  function automatic logic [PASS_W-1:0] finalPass(input logic [MODE_W-1:0] mode);
    case (mode)
      2'd2:    finalPass = PASS_W'(1);
      2'd3:    finalPass = PASS_W'(2);
      default: finalPass = PASS_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/msaa_seq_ctrl.sv
module msaa_seq_ctrl
  import msaa_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fragValid,
  input  logic              wrReady,
  input  logic [PASS_W-1:0] lastPass,
  output logic              fragReady,
  output logic              wrValid,
  output logic              wrLast,
  output seq_ctrl_t         ctl
);
  logic              busy;
  logic [PASS_W-1:0] passQ;

  assign fragReady = !busy;
  assign wrValid   = busy;
  assign wrLast    = busy && (passQ == lastPass);

  always_comb begin
    ctl.load = fragValid && !busy;
    ctl.pass = passQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      passQ <= '0;
    end else if (ctl.load) begin
      busy  <= 1'b1;
      passQ <= '0;
    end else if (busy && wrReady) begin
      if (passQ == lastPass) begin
        busy  <= 1'b0;
        passQ <= '0;
      end else begin
        passQ <= passQ + PASS_W'(1);
      end
    end
  end
endmodule

// File: rtl/msaa_seq_datapath.sv
module msaa_seq_datapath
  import msaa_pkg::*;
#(
  parameter int COLOR_W = 32,
  parameter int DEPTH_W = 24,
  parameter int COORD_W = 12,
  parameter int GRID_N  = 12,
  localparam int POS_W  = $clog2(GRID_N)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seq_ctrl_t               ctl,
  input  logic [MODE_W-1:0]       modeSel,
  input  logic                    frameOdd,
  input  logic                    tblWe,
  input  logic                    tblSel,
  input  logic [IDX_W-1:0]        tblIdx,
  input  logic [POS_W-1:0]        tblX,
  input  logic [POS_W-1:0]        tblY,
  input  logic [COLOR_W-1:0]      fragColor,
  input  logic [DEPTH_W-1:0]      fragDepth,
  input  logic [MAX_SAMP-1:0]     fragCover,
  input  logic [COORD_W-1:0]      fragX,
  input  logic [COORD_W-1:0]      fragY,
  output logic [PASS_W-1:0]       lastPass,
  output logic [COORD_W-1:0]      wrX,
  output logic [COORD_W-1:0]      wrY,
  output logic [COLOR_W-1:0]      wrColor,
  output logic [DEPTH_W-1:0]      wrDepth,
  output logic [LANES*IDX_W-1:0]  wrIdx,
  output logic [LANES*POS_W-1:0]  wrPosX,
  output logic [LANES*POS_W-1:0]  wrPosY,
  output logic [LANES-1:0]        wrEn
);
  localparam logic [POS_W-1:0] POS_MAX  = POS_W'(GRID_N - 1);
  localparam logic [IDX_W-1:0] SAMP_LIM = IDX_W'(MAX_SAMP);

  // Two programmable position tables.
  logic [POS_W-1:0] tabX [2][MAX_SAMP];
  logic [POS_W-1:0] tabY [2][MAX_SAMP];

  logic [POS_W-1:0] clampX, clampY;
  assign clampX = (tblX > POS_MAX) ? POS_MAX : tblX;
  assign clampY = (tblY > POS_MAX) ? POS_MAX : tblY;

  for (genvar t = 0; t < 2; t++) begin : gTable
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < MAX_SAMP; i++) begin
          tabX[t][i] <= POS_W'((2 * i + 1) % GRID_N);
          tabY[t][i] <= POS_W'((GRID_N - 2 - 2 * i) % GRID_N);
        end
      end else if (tblWe && (tblSel == 1'(t)) && (tblIdx < SAMP_LIM)) begin
        tabX[t][tblIdx] <= clampX;
        tabY[t][tblIdx] <= clampY;
      end
    end
  end

  // Fragment held for all its passes, with a private copy of its pattern.
  logic [COLOR_W-1:0]  hColor;
  logic [DEPTH_W-1:0]  hDepth;
  logic [MAX_SAMP-1:0] hCover;
  logic [COORD_W-1:0]  hX, hY;
  logic [MODE_W-1:0]   hMode;
  logic [POS_W-1:0]    snapX [MAX_SAMP];
  logic [POS_W-1:0]    snapY [MAX_SAMP];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hColor <= '0;
      hDepth <= '0;
      hCover <= '0;
      hX     <= '0;
      hY     <= '0;
      hMode  <= '0;
      for (int i = 0; i < MAX_SAMP; i++) begin
        snapX[i] <= '0;
        snapY[i] <= '0;
      end
    end else if (ctl.load) begin
      hColor <= fragColor;
      hDepth <= fragDepth;
      hCover <= fragCover;
      hX     <= fragX;
      hY     <= fragY;
      hMode  <= modeSel;
      for (int i = 0; i < MAX_SAMP; i++) begin
        snapX[i] <= tabX[frameOdd][i];
        snapY[i] <= tabY[frameOdd][i];
      end
    end
  end

  logic [IDX_W-1:0] hCount;
  assign hCount   = sampleCount(hMode);
  assign lastPass = finalPass(hMode);

  assign wrX     = hX;
  assign wrY     = hY;
  assign wrColor = hColor;
  assign wrDepth = hDepth;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic [IDX_W-1:0] laneIdx;
    logic             inRange;
    assign laneIdx = IDX_W'({ctl.pass, 1'b0}) + IDX_W'(l);
    assign inRange = laneIdx < SAMP_LIM;
    assign wrIdx[l*IDX_W +: IDX_W]  = laneIdx;
    assign wrPosX[l*POS_W +: POS_W] = inRange ? snapX[laneIdx] : '0;
    assign wrPosY[l*POS_W +: POS_W] = inRange ? snapY[laneIdx] : '0;
    assign wrEn[l] = inRange && hCover[laneIdx] && (laneIdx < hCount);
  end
endmodule

// File: rtl/msaa_write_seq.sv
module msaa_write_seq
  import msaa_pkg::*;
#(
  parameter int COLOR_W = 32,
  parameter int DEPTH_W = 24,
  parameter int COORD_W = 12,
  parameter int GRID_N  = 12,
  localparam int POS_W  = $clog2(GRID_N)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [MODE_W-1:0]      modeSel,
  input  logic                   frameOdd,
  input  logic                   tblWe,
  input  logic                   tblSel,
  input  logic [IDX_W-1:0]       tblIdx,
  input  logic [POS_W-1:0]       tblX,
  input  logic [POS_W-1:0]       tblY,
  input  logic                   fragValid,
  output logic                   fragReady,
  input  logic [COLOR_W-1:0]     fragColor,
  input  logic [DEPTH_W-1:0]     fragDepth,
  input  logic [MAX_SAMP-1:0]    fragCover,
  input  logic [COORD_W-1:0]     fragX,
  input  logic [COORD_W-1:0]     fragY,
  output logic                   wrValid,
  input  logic                   wrReady,
  output logic                   wrLast,
  output logic [COORD_W-1:0]     wrX,
  output logic [COORD_W-1:0]     wrY,
  output logic [COLOR_W-1:0]     wrColor,
  output logic [DEPTH_W-1:0]     wrDepth,
  output logic [LANES*IDX_W-1:0] wrIdx,
  output logic [LANES*POS_W-1:0] wrPosX,
  output logic [LANES*POS_W-1:0] wrPosY,
  output logic [LANES-1:0]       wrEn
);
  seq_ctrl_t         ctl;
  logic [PASS_W-1:0] lastPass;

  msaa_seq_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .fragValid (fragValid),
    .wrReady   (wrReady),
    .lastPass  (lastPass),
    .fragReady (fragReady),
    .wrValid   (wrValid),
    .wrLast    (wrLast),
    .ctl       (ctl)
  );

  msaa_seq_datapath #(
    .COLOR_W (COLOR_W),
    .DEPTH_W (DEPTH_W),
    .COORD_W (COORD_W),
    .GRID_N  (GRID_N)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .modeSel   (modeSel),
    .frameOdd  (frameOdd),
    .tblWe     (tblWe),
    .tblSel    (tblSel),
    .tblIdx    (tblIdx),
    .tblX      (tblX),
    .tblY      (tblY),
    .fragColor (fragColor),
    .fragDepth (fragDepth),
    .fragCover (fragCover),
    .fragX     (fragX),
    .fragY     (fragY),
    .lastPass  (lastPass),
    .wrX       (wrX),
    .wrY       (wrY),
    .wrColor   (wrColor),
    .wrDepth   (wrDepth),
    .wrIdx     (wrIdx),
    .wrPosX    (wrPosX),
    .wrPosY    (wrPosY),
    .wrEn      (wrEn)
  );
endmodule

// File: rtl/msaa_write_seq_chk.sv
module msaa_write_seq_chk
  import msaa_pkg::*;
#(
  parameter int COLOR_W = 32,
  parameter int DEPTH_W = 24,
  parameter int GRID_N  = 12,
  localparam int POS_W  = $clog2(GRID_N)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [MODE_W-1:0]      modeSel,
  input logic                   fragValid,
  input logic                   fragReady,
  input logic [COLOR_W-1:0]     fragColor,
  input logic [DEPTH_W-1:0]     fragDepth,
  input logic                   wrValid,
  input logic                   wrReady,
  input logic                   wrLast,
  input logic [COLOR_W-1:0]     wrColor,
  input logic [DEPTH_W-1:0]     wrDepth,
  input logic [LANES*IDX_W-1:0] wrIdx,
  input logic [LANES*POS_W-1:0] wrPosX,
  input logic [LANES*POS_W-1:0] wrPosY,
  input logic [LANES-1:0]       wrEn
);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(GRID_N - 1);

  logic [MODE_W-1:0]  cMode;
  logic [COLOR_W-1:0] cColor;
  logic [DEPTH_W-1:0] cDepth;
  logic [IDX_W-1:0]   cLastIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cMode  <= '0;
      cColor <= '0;
      cDepth <= '0;
    end else if (fragValid && fragReady) begin
      cMode  <= modeSel;
      cColor <= fragColor;
      cDepth <= fragDepth;
    end
  end

  assign cLastIdx = (cMode == 2'd3) ? IDX_W'(4) : (cMode == 2'd2) ? IDX_W'(2) : IDX_W'(0);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fragValid && fragReady) |=> (wrValid && !fragReady));

  assert_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady && wrLast) |=> (fragReady && !wrValid));

  assert_first_beat_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fragValid && fragReady) |=> (wrIdx[IDX_W-1:0] == '0));

  assert_last_beat_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrLast) |-> (wrIdx[IDX_W-1:0] == cLastIdx));

  assert_lane_pair_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (!wrIdx[0] && (wrIdx[2*IDX_W-1:IDX_W] == IDX_W'(wrIdx[IDX_W-1:0] + IDX_W'(1)))));

  assert_single_lane_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && cMode == 2'd0) |-> !wrEn[1]);

  assert_data_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrColor == cColor && wrDepth == cDepth));

  assert_on_grid_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrPosX[POS_W-1:0] <= POS_MAX && wrPosX[2*POS_W-1:POS_W] <= POS_MAX &&
                 wrPosY[POS_W-1:0] <= POS_MAX && wrPosY[2*POS_W-1:POS_W] <= POS_MAX));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrIdx) && $stable(wrPosX) && $stable(wrPosY) &&
                               $stable(wrEn) && $stable(wrColor) && $stable(wrLast)));
endmodule

bind msaa_write_seq msaa_write_seq_chk #(
  .COLOR_W (COLOR_W),
  .DEPTH_W (DEPTH_W),
  .GRID_N  (GRID_N)
) uChk (.*);

// File: tb/tb_msaa_write_seq.sv
module tb_msaa_write_seq;
  import msaa_pkg::*;
  localparam int CW = 32, DW = 24, XW = 12;

  logic clk = 0, rstN = 0;
  logic [1:0] modeSel = 0;
  logic frameOdd = 0, tblWe = 0, tblSel = 0;
  logic [2:0] tblIdx = 0;
  logic [3:0] tblX = 0, tblY = 0;
  logic fragValid = 0, fragReady;
  logic [CW-1:0] fragColor = 0;
  logic [DW-1:0] fragDepth = 0;
  logic [5:0] fragCover = 0;
  logic [XW-1:0] fragX = 0, fragY = 0;
  logic wrValid, wrReady = 0, wrLast;
  logic [XW-1:0] wrX, wrY;
  logic [CW-1:0] wrColor;
  logic [DW-1:0] wrDepth;
  logic [5:0] wrIdx;
  logic [7:0] wrPosX, wrPosY;
  logic [1:0] wrEn;

  msaa_write_seq dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [3:0] mX [2][6];
  logic [3:0] mY [2][6];
  logic [3:0] sX [6];
  logic [3:0] sY [6];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R2 watchdog expired act=%0d exp<=150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sampCnt(input logic [1:0] m);
    return (m == 0) ? 1 : (m == 1) ? 2 : (m == 2) ? 4 : 6;
  endfunction

  function automatic int passCnt(input logic [1:0] m);
    return (m == 3) ? 3 : (m == 2) ? 2 : 1;
  endfunction

  function automatic logic [3:0] clampPos(input logic [3:0] v);
    return (v > 4'd11) ? 4'd11 : v;
  endfunction

  task automatic checkBeat(input int p, input logic [1:0] m, input logic [5:0] cov,
                           input logic [CW-1:0] c, input logic [DW-1:0] d,
                           input logic [XW-1:0] x, input logic [XW-1:0] y, input string tag);
    chk("R2", {tag, " wrValid"}, wrValid, 1);
    chk("R3", {tag, " wrLast"}, wrLast, (p == passCnt(m) - 1));
    chk("R6", {tag, " colour/depth"}, {wrColor, wrDepth}, {c, d});
    chk("R6", {tag, " coords"}, {wrX, wrY}, {x, y});
    for (int l = 0; l < 2; l++) begin
      int s = 2 * p + l;
      chk("R4", {tag, " lane index"}, wrIdx[l*3 +: 3], s);
      chk("R5", {tag, " lane enable"}, wrEn[l], cov[s] && (s < sampCnt(m)));
      chk("R7", {tag, " pos x"}, wrPosX[l*4 +: 4], sX[s]);
      chk("R7", {tag, " pos y"}, wrPosY[l*4 +: 4], sY[s]);
    end
  endtask

  task automatic writeTbl(input logic sel, input logic [2:0] idx, input logic [3:0] x, input logic [3:0] y);
    tblWe = 1; tblSel = sel; tblIdx = idx; tblX = x; tblY = y;
    @(posedge clk);
    mX[sel][idx] = clampPos(x);
    mY[sel][idx] = clampPos(y);
    @(negedge clk);
    tblWe = 0;
  endtask

  task automatic runFrag(input logic [1:0] m, input logic odd, input logic [5:0] cov,
                         input int stall, input bit midWr, input bit sameWr);
    logic [CW-1:0] c = $urandom;
    logic [DW-1:0] d = DW'($urandom);
    logic [XW-1:0] x = XW'($urandom);
    logic [XW-1:0] y = XW'($urandom);
    logic [2:0] wIdx = 3'($urandom % 6);
    logic [3:0] wx = 4'($urandom), wy = 4'($urandom);
    chk("R2", "ready before offer", fragReady, 1);
    modeSel = m; frameOdd = odd; fragCover = cov;
    fragColor = c; fragDepth = d; fragX = x; fragY = y; fragValid = 1;
    if (sameWr) begin
      tblWe = 1; tblSel = odd; tblIdx = wIdx; tblX = wx; tblY = wy;
    end
    @(posedge clk);
    for (int i = 0; i < 6; i++) begin
      sX[i] = mX[odd][i];
      sY[i] = mY[odd][i];
    end
    if (sameWr) begin
      mX[odd][wIdx] = clampPos(wx);
      mY[odd][wIdx] = clampPos(wy);
    end
    @(negedge clk);
    fragValid = 0; tblWe = 0;
    frameOdd = ~odd; modeSel = 2'($urandom); fragCover = ~cov; fragColor = ~c;
    chk("R2", "ready low while busy", fragReady, 0);
    for (int p = 0; p < passCnt(m); p++) begin
      checkBeat(p, m, cov, c, d, x, y, "beat");
      if (p == 0 && stall > 0) begin
        if (midWr) writeTbl(odd, 3'($urandom % 6), 4'($urandom), 4'($urandom));
        repeat (stall) @(negedge clk);
        checkBeat(p, m, cov, c, d, x, y, "R10 R9 after stall");
      end
      wrReady = 1;
      @(posedge clk);
      @(negedge clk);
      wrReady = 0;
    end
    chk("R2", "ready after last beat", fragReady, 1);
    chk("R2", "valid after last beat", wrValid, 0);
  endtask

  initial begin
    int unsigned seedSet = $urandom(32'd4242);
    if (seedSet == 0) $display("seed applied");
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 6; i++) begin
        mX[t][i] = 4'(2 * i + 1);
        mY[t][i] = 4'(10 - 2 * i);
      end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1", "fragReady after reset", fragReady, 1);
    chk("R1", "wrValid after reset", wrValid, 0);
    // R11: reset patterns of both tables, full coverage.
    runFrag(2'd3, 1'b0, 6'h3f, 0, 0, 0);
    runFrag(2'd3, 1'b1, 6'h3f, 0, 0, 0);
    // R5: single-sample mode and a sparse mask.
    runFrag(2'd0, 1'b0, 6'h3f, 0, 0, 0);
    runFrag(2'd2, 1'b1, 6'b001010, 1, 0, 0);
    // R8: out-of-grid values clamp to 11.
    writeTbl(1'b0, 3'd3, 4'd15, 4'd13);
    runFrag(2'd3, 1'b0, 6'h3f, 0, 0, 0);
    // R9: write during stall and in the acceptance cycle.
    runFrag(2'd3, 1'b1, 6'h3f, 2, 1, 1);
    // Random mix.
    for (int k = 0; k < 60; k++) begin
      if ($urandom % 4 == 0)
        writeTbl(1'($urandom), 3'($urandom % 6), 4'($urandom), 4'($urandom));
      runFrag(2'($urandom), 1'($urandom), 6'($urandom), int'($urandom % 3),
              bit'($urandom), ($urandom % 4) == 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule